// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a serial two's-complement stereo stream made of a bit clock, a frame clock and one or two data lines, and turns it into a parallel left/right sample pair. All serial pins are sampled by the system clock through short synchronizer chains. Bit-clock and frame-clock edges are detected in the system clock domain, so the serial clocks must be several times slower than the system clock. Each delivered pair comes with a one-cycle `valid` pulse. A separate one-cycle `frame_start` pulse marks the edge that opens each frame, for timing logic further down the chain.

Two mode pins select one of three framings, and in doing so they change the role of the other pins. With `fmt_sel` low, `pin_a` carries the data, and `pin_b`/`pin_c` give the word length of a right-justified word, whose LSB ends just before the frame clock toggles. With `fmt_sel` high, `pin_a` becomes a mode bit. When it is low, the data arrives on `pin_b`, one channel per frame-clock level, MSB first from the frame-clock edge. When it is high, the left data arrives on `pin_b` and the right data on `pin_c`, side by side. In both of these modes the word is 20 bits long. Words shorter than the output width are placed in the upper bits of the output, so the sign bit always lands in the top bit.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low, `out_l` and `out_r` read zero, and `valid` and `frame_start` are low.
- R2: With `fmt_sel`=0, the data is on `pin_a`. The left word is sent while `frm` is high and the right word while `frm` is low. Each word is the last N bits shifted in before `frm` toggles, with the MSB first.
- R3: With `fmt_sel`=0, N is set by the length pins. `pin_b`=0 gives 20 bits, `pin_b`=1 with `pin_c`=0 gives 18 bits, and `pin_b`=1 with `pin_c`=1 gives 16 bits.
- R4: A word shorter than OUT_W is placed in the upper bits of the output, and the unused low bits are zero.
- R5: With `fmt_sel`=1 and `pin_a`=0, the data is on `pin_b`. The left word is sent while `frm` is low and the right word while `frm` is high. Each word is the first 20 bits after the `frm` edge, with the MSB first.
- R6: In the two MSB-first modes, bits after the 20th bit of a word have no effect on the outputs.
- R7: With `fmt_sel`=1 and `pin_a`=1, the left data is on `pin_b` and the right data on `pin_c`. Both words are the first 20 bits after the rising edge of `frm`. Bits sent while `frm` is low are ignored.
- R8: `frame_start` pulses for exactly one cycle at each frame-opening edge of `frm`. This is the falling edge in the `fmt_sel`=1, `pin_a`=0 mode and the rising edge in the other two modes.
- R9: `valid` pulses for exactly one cycle per frame, and only after both words of the same frame have been captured. A frame cut short by reset produces no pulse. `out_l` and `out_r` change only together with `valid`.
- R10: Data bits are taken at the rising edge of `bck`. A data level that appears while `bck` is high, after that rising edge, does not affect the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck | input | 1 | Serial bit clock |
| frm | input | 1 | Serial frame (channel) clock |
| fmt_sel | input | 1 | Selects the right-justified single-line mode (0) or the MSB-first modes (1) |
| pin_a | input | 1 | Data (fmt_sel=0) or MSB-first mode select (fmt_sel=1) |
| pin_b | input | 1 | Length select 1 (fmt_sel=0) or data / left data (fmt_sel=1) |
| pin_c | input | 1 | Length select 2 (fmt_sel=0) or right data (fmt_sel=1) |
| out_l | output | OUT_W | Left sample, MSB-aligned |
| out_r | output | OUT_W | Right sample, MSB-aligned |
| valid | output | 1 | One-cycle pulse when a sample pair is delivered |
| frame_start | output | 1 | One-cycle pulse at each frame-opening edge |

## Verification
The bench uses the default parameters: a 20-bit output, two synchronizer stages, and shorter lengths of 18 and 16 bits. The width of 20 lets the three trailing lengths produce zero pads of 0, 2 and 4 bits, all of which are checked. The two-stage synchronizer, together with an 8-cycle bit period, leaves enough room to drive a deliberately wrong data level in the second half of each high phase of `bck`. The 24-bit half frames leave four spare bits after each 20-bit word in the MSB-first modes. Each mode also starts once from a truncated frame after reset, to show that no pair is delivered from it.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int OUT_W     = 20,
  parameter int SYNC      = 2,
  parameter int LEN_MID   = 18,
  parameter int LEN_SHORT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bck,
  input  logic             frm,
  input  logic             fmt_sel,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             pin_c,
  output logic [OUT_W-1:0] out_l,
  output logic [OUT_W-1:0] out_r,
  output logic             valid,
  output logic             frame_start
);

  localparam int CW = $clog2(OUT_W + 1);

  logic [SYNC:0]   s_bck, s_frm;
  logic [SYNC-1:0] s_a, s_b, s_c;

  always_ff @(posedge clk) begin
    s_bck <= {s_bck[SYNC-1:0], bck};
    s_frm <= {s_frm[SYNC-1:0], frm};
    s_a   <= {s_a[SYNC-2:0], pin_a};
    s_b   <= {s_b[SYNC-2:0], pin_b};
    s_c   <= {s_c[SYNC-2:0], pin_c};
  end

  logic bck_s, frm_s, a_s, b_s, c_s;
  assign bck_s = s_bck[SYNC-1];
  assign frm_s = s_frm[SYNC-1];
  assign a_s   = s_a[SYNC-1];
  assign b_s   = s_b[SYNC-1];
  assign c_s   = s_c[SYNC-1];

  logic trail, lead_alt, simul;
  assign trail    = !fmt_sel;
  assign lead_alt = fmt_sel && !a_s;
  assign simul    = fmt_sel && a_s;

  logic bck_rise, frm_rise, frm_fall, frm_edge, start_edge, left_phase;
  assign bck_rise   = bck_s && !s_bck[SYNC];
  assign frm_rise   = frm_s && !s_frm[SYNC];
  assign frm_fall   = !frm_s && s_frm[SYNC];
  assign frm_edge   = frm_rise || frm_fall;
  assign start_edge = lead_alt ? frm_fall : frm_rise;
  assign left_phase = lead_alt ? !frm_s : frm_s;

  logic dat0, dat1;
  assign dat0 = trail ? a_s : b_s;
  assign dat1 = c_s;

  logic [CW-1:0] nbits;
  assign nbits = (!trail || !b_s) ? CW'(OUT_W) : (c_s ? CW'(LEN_SHORT) : CW'(LEN_MID));

  logic [CW-1:0]    cnt;
  logic [OUT_W-1:0] sh0, sh1, tw, lw;
  logic             cnt_clr, cnt_full, shift_en, done, done_q, got_l, armed;

  assign cnt_clr  = simul ? start_edge : frm_edge;
  assign cnt_full = (cnt == CW'(OUT_W));
  assign shift_en = bck_rise && !cnt_clr && (trail || !cnt_full);
  assign done     = !trail && bck_rise && !cnt_clr && (cnt == CW'(OUT_W - 1));
  assign tw       = sh0 << (CW'(OUT_W) - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CW'(OUT_W);
      sh0 <= '0;
      sh1 <= '0;
    end else begin
      if (cnt_clr)
        cnt <= '0;
      else if (bck_rise && !cnt_full)
        cnt <= cnt + 1'b1;
      if (shift_en) begin
        sh0 <= {sh0[OUT_W-2:0], dat0};
        sh1 <= {sh1[OUT_W-2:0], dat1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw          <= '0;
      out_l       <= '0;
      out_r       <= '0;
      got_l       <= 1'b0;
      armed       <= 1'b0;
      valid       <= 1'b0;
      frame_start <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      valid       <= 1'b0;
      frame_start <= start_edge;
      done_q      <= done;
      if (trail) begin
        if (frm_edge) begin
          armed <= 1'b1;
          if (armed) begin
            if (!left_phase) begin
              lw    <= tw;
              got_l <= 1'b1;
            end else if (got_l) begin
              out_l <= lw;
              out_r <= tw;
              valid <= 1'b1;
              got_l <= 1'b0;
            end
          end
        end
      end else if (done_q) begin
        if (simul) begin
          out_l <= sh0;
          out_r <= sh1;
          valid <= 1'b1;
        end else if (left_phase) begin
          lw    <= sh0;
          got_l <= 1'b1;
        end else if (got_l) begin
          out_l <= lw;
          out_r <= sh0;
          valid <= 1'b1;
          got_l <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int OUT_W     = 20,
  parameter int LEN_MID   = 18,
  parameter int LEN_SHORT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fmt_sel,
  input logic             pin_b,
  input logic             pin_c,
  input logic [OUT_W-1:0] out_l,
  input logic [OUT_W-1:0] out_r,
  input logic             valid,
  input logic             frame_start
);

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(out_l) && $stable(out_r)));

  a_r4_short_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !fmt_sel && pin_b && pin_c) |->
      (out_l[OUT_W-LEN_SHORT-1:0] == '0 && out_r[OUT_W-LEN_SHORT-1:0] == '0));

  a_r4_mid_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !fmt_sel && pin_b && !pin_c) |->
      (out_l[OUT_W-LEN_MID-1:0] == '0 && out_r[OUT_W-LEN_MID-1:0] == '0));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(
  .OUT_W(OUT_W), .LEN_MID(LEN_MID), .LEN_SHORT(LEN_SHORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .pin_b(pin_b), .pin_c(pin_c),
  .out_l(out_l), .out_r(out_r), .valid(valid), .frame_start(frame_start)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
  localparam int W = 20;
  localparam int H = 24;

  logic clk = 0, rst_n = 0, bck = 0, frm = 0;
  logic fmt_sel = 0, pin_a = 0, pin_b = 0, pin_c = 0;
  logic [W-1:0] out_l, out_r;
  logic valid, frame_start;

  always #10 clk = ~clk;

  serial_audio_rx dut (
    .clk(clk), .rst_n(rst_n), .bck(bck), .frm(frm), .fmt_sel(fmt_sel),
    .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
    .out_l(out_l), .out_r(out_r), .valid(valid), .frame_start(frame_start)
  );

  int n_chk = 0, n_fail = 0, fs_cnt = 0, dmode = 0;
  bit finished = 0;
  logic [W-1:0] ql[$], qr[$];
  string qt[$];
  logic [W-1:0] el, er;
  string et;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(bit d0, bit d1);
    case (dmode)
      0: pin_a = d0;
      1: pin_b = d0;
      default: begin pin_b = d0; pin_c = d1; end
    endcase
  endtask

  // R10: correct level around the rising edge, inverted level later in the high phase
  task automatic send_bit(bit d0, bit d1);
    bck = 0; drive(d0, d1); tick(4);
    bck = 1; tick(2);
    drive(!d0, !d1); tick(2);
  endtask

  task automatic push(logic [W-1:0] l, logic [W-1:0] r, string tag);
    ql.push_back(l); qr.push_back(r); qt.push_back(tag);
  endtask

  function automatic logic [W-1:0] align(logic [W-1:0] w, int n);
    logic [W-1:0] m = (W'(1) << n) - 1'b1;
    return (w & m) << (W - n);
  endfunction

  task automatic setup(int m, bit s1, bit s2, bit f0);
    rst_n = 0; dmode = m;
    fmt_sel = (m != 0); pin_a = (m == 2);
    pin_b = (m == 0) ? s1 : 1'b0; pin_c = (m == 0) ? s2 : 1'b0;
    frm = f0; bck = 0;
    tick(6);
    check(out_l == 0 && out_r == 0 && !valid && !frame_start, "R1 reset state",
          {out_l, out_r, valid, frame_start}, 0);
    rst_n = 1; tick(4);
    fs_cnt = 0;
  endtask

  task automatic end_seg(string tag, int exp_fs);
    tick(20);
    check(ql.size() == 0, {tag, " all pairs delivered (R9)"}, ql.size(), 0);
    check(fs_cnt == exp_fs, {tag, " frame_start count (R8)"}, fs_cnt, exp_fs);
  endtask

  task automatic half_garbage(bit level, int nb);
    frm = level;
    for (int i = 0; i < nb; i++) send_bit(i[1], !i[0]);
  endtask

  task automatic trail_frame(int n, logic [W-1:0] l, logic [W-1:0] r, string tag);
    push(align(l, n), align(r, n), tag);
    frm = 1;
    for (int i = 0; i < H; i++) send_bit((i >= H - n) ? l[H-1-i] : i[0], 1'b0);
    frm = 0;
    for (int i = 0; i < H; i++) send_bit((i >= H - n) ? r[H-1-i] : !i[0], 1'b0);
  endtask

  task automatic lead_frame(logic [W-1:0] l, logic [W-1:0] r, string tag);
    push(l, r, tag);
    frm = 0;
    for (int i = 0; i < H; i++) send_bit((i < W) ? l[W-1-i] : i[0], 1'b0);
    frm = 1;
    for (int i = 0; i < H; i++) send_bit((i < W) ? r[W-1-i] : !i[0], 1'b0);
  endtask

  task automatic simul_frame(logic [W-1:0] l, logic [W-1:0] r, string tag);
    push(l, r, tag);
    frm = 1;
    for (int i = 0; i < H; i++)
      send_bit((i < W) ? l[W-1-i] : !i[0], (i < W) ? r[W-1-i] : i[0]);
    frm = 0;
    for (int i = 0; i < H; i++) send_bit(i[0], i[1]);
  endtask

  task automatic flush_rise();
    frm = 1; tick(8);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_start) fs_cnt++;
      if (valid) begin
        if (ql.size() == 0) begin
          check(0, "R9 unexpected valid", {out_l, out_r}, 0);
        end else begin
          el = ql.pop_front(); er = qr.pop_front(); et = qt.pop_front();
          check({out_l, out_r} == {el, er}, et, {out_l, out_r}, {el, er});
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    // R2 R3 R4: right-justified, 16-bit words
    setup(0, 1, 1, 0);
    trail_frame(16, 20'h08001, 20'h07ffe, "R2 R3 R4 trail16 f1");
    trail_frame(16, 20'h0ffff, 20'h00001, "R2 R3 R4 trail16 f2");
    trail_frame(16, 20'h0a5c3, 20'h05a3c, "R2 R3 R10 trail16 f3");
    flush_rise();
    end_seg("R2 trail16", 4);

    // R3 R4: 18-bit words
    setup(0, 1, 0, 0);
    trail_frame(18, 20'h20001, 20'h1fffe, "R3 R4 trail18 f1");
    trail_frame(18, 20'h2aaaa, 20'h15555, "R3 R4 trail18 f2");
    flush_rise();
    end_seg("R3 trail18", 3);

    // R2 R9: 20-bit words after a truncated first frame
    setup(0, 0, 1, 1);
    half_garbage(1, 10);
    half_garbage(0, H);
    trail_frame(20, 20'h80000, 20'h7ffff, "R2 R9 trail20 f1");
    trail_frame(20, 20'hc3a51, 20'h1b2e4, "R2 trail20 f2");
    flush_rise();
    end_seg("R9 trail20", 3);

    // R5 R6 R9: MSB-first alternating, partial start, extra bits
    setup(1, 0, 0, 0);
    half_garbage(0, 10);
    half_garbage(1, H);
    lead_frame(20'h80001, 20'h7fffe, "R5 R6 lead f1");
    lead_frame(20'h12345, 20'hedcba, "R5 R6 lead f2");
    lead_frame(20'hfffff, 20'h00000, "R5 R10 lead f3");
    end_seg("R5 lead", 3);

    // R7 R8: two data lines, second half ignored
    setup(2, 0, 0, 0);
    half_garbage(0, 12);
    simul_frame(20'h9abcd, 20'h43210, "R7 simul f1");
    simul_frame(20'h00001, 20'h80000, "R7 simul f2");
    simul_frame(20'h5a5a5, 20'ha5a5a, "R7 R10 simul f3");
    end_seg("R7 simul", 3);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule